// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Alternate-Function Override

This block controls an eight-pin bidirectional I/O port through three memory-mapped registers on a simple synchronous register bus. The registers are an output latch, a per-pin direction mask and a pin-assignment mask. Each pin either drives its latch value with the output enable high, or floats as an input whose level is synchronized and can be read back over the bus. The pad itself lives outside the block, so each pin appears here as a separate input, output and output-enable triple.

Two sources can take a pin away from general-purpose use. Assignment bits 5..0 turn pins 5..0 into expansion address lines. These are fed from outside the block and carry address bits 18..13 in that pin order. The two-bit operating mode can also hand pin 7 to a read/write strobe. An override of either kind forces the pin to drive the alternate signal, but it never writes the stored direction bit. When the override is removed, the pin goes back to whatever its direction bit selects.

Top module: `gpio_altport`

## Requirements
- R1: After reset, the direction, latch and assignment registers are all zero, and pins 6..0 have their output enable low.
- R2: A pin with no alternate function drives its latch bit when its direction bit is 1 (output enable high) and floats when its direction bit is 0 (output enable low).
- R3: When assignment bit i (i in 0..5) is 1, pin i has its output enable high and drives external address input bit i, whatever its direction bit holds. The direction register reads back unchanged.
- R4: Assignment register bits 7..6 always read as 0, including after a write of ones.
- R5: Once an assignment bit or the strobe mode is removed, that pin's output enable and output return to direction-register and latch control.
- R6: Mode encodings 2'b01 (expanded) and 2'b11 (special test) force pin 7 to drive the strobe input with its output enable high. Encodings 2'b00 (single-chip) and 2'b10 (bootstrap) leave pin 7 under its direction bit.
- R7: The latch is at address 0x7E, direction at 0x7F and assignment at 0x2D. Any other address reads 0, and a write to it changes no register.
- R8: The bit for a floating pin in a read of 0x7E is the pin level as it was two clock edges earlier. Direction-controlled output pins return their latch bit, and overridden pins return the level actually driven.
- R9: The read data is combinational on the address. A write is captured on the rising edge where the write strobe is high and becomes visible from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 special test |
| bus_addr | input | 8 | Register address for both read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| xa_addr | input | 6 | Expansion address bits 18..13 for pins 5..0 |
| rw_strobe | input | 1 | Read/write strobe for pin 7 |
| pin_in | input | 8 | Levels seen at the pads |
| pin_out | output | 8 | Values presented to the pads |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench builds the block with its default parameters: eight pins, six assignable address pins and the strobe on pin 7. At that size all 64 assignment patterns can be swept. Each pattern is paired with a different direction mask, latch value, mode code and alternate-signal value, so every override combination, and every mode for the pin 7 strobe, is compared against masks the bench computes itself. Directed steps cover the two-edge input latency, address decode misses, the unimplemented assignment bits and the write timing.

// File: rtl/gpio_altport_pkg.sv
package gpio_altport_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE   = 2'b00,
      MODE_EXPANDED = 2'b01,
      MODE_BOOT     = 2'b10,
      MODE_TEST     = 2'b11
   } port_mode_e;

   // Only the two bus-driving modes hand the top pin to the strobe.
   function automatic logic strobe_mode(input logic [1:0] m);
      return (m == MODE_EXPANDED) || (m == MODE_TEST);
   endfunction

endpackage

// File: rtl/gpio_altport_sync.sv
module gpio_altport_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("gpio_altport_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_altport_regs.sv
module gpio_altport_regs #(
   parameter int          W      = 8,
   parameter int          AW     = 8,
   parameter int          ASG_W  = 6,
   parameter logic [AW-1:0] DATA_A = 8'h7E,
   parameter logic [AW-1:0] DIR_A  = 8'h7F,
   parameter logic [AW-1:0] ASG_A  = 8'h2D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic [W-1:0]     bus_wdata,
   input  logic [W-1:0]     port_rb,
   output logic [W-1:0]     bus_rdata,
   output logic [W-1:0]     data_q,
   output logic [W-1:0]     dir_q,
   output logic [ASG_W-1:0] asgn_q
);

   localparam int PAD_W = W - ASG_W;

   if (DATA_A == DIR_A || DATA_A == ASG_A || DIR_A == ASG_A) begin : g_bad_map
      $error("gpio_altport_regs: register addresses must differ");
   end
   if (PAD_W < 0) begin : g_bad_asg
      $error("gpio_altport_regs: ASG_W exceeds W");
   end

   logic hit_data, hit_dir, hit_asg;
   assign hit_data = (bus_addr == DATA_A);
   assign hit_dir  = (bus_addr == DIR_A);
   assign hit_asg  = (bus_addr == ASG_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (bus_wr && hit_data) begin
         data_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (bus_wr && hit_dir) begin
         dir_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asgn_q <= '0;
      end else if (bus_wr && hit_asg) begin
         asgn_q <= bus_wdata[ASG_W-1:0];
      end
   end

   logic [W-1:0] asg_view;
   if (PAD_W > 0) begin : g_asg_pad
      assign asg_view = {{PAD_W{1'b0}}, asgn_q};
   end else begin : g_asg_full
      assign asg_view = asgn_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_data) bus_rdata = port_rb;
      if (hit_dir)  bus_rdata = dir_q;
      if (hit_asg)  bus_rdata = asg_view;
   end

endmodule

// File: rtl/gpio_altport_pinmux.sv
module gpio_altport_pinmux
   import gpio_altport_pkg::*;
#(
   parameter int W          = 8,
   parameter int ASG_W      = 6,
   parameter int STROBE_PIN = 7
) (
   input  logic [1:0]       mode,
   input  logic [W-1:0]     data_q,
   input  logic [W-1:0]     dir_q,
   input  logic [ASG_W-1:0] asgn_q,
   input  logic [ASG_W-1:0] xa_addr,
   input  logic             rw_strobe,
   input  logic [W-1:0]     sync_in,
   output logic [W-1:0]     pin_out,
   output logic [W-1:0]     pin_oe,
   output logic [W-1:0]     port_rb
);

   if (STROBE_PIN < ASG_W || STROBE_PIN >= W) begin : g_bad_strobe
      $error("gpio_altport_pinmux: STROBE_PIN must lie above the address pins");
   end

   logic strobe_on;
   assign strobe_on = strobe_mode(mode);

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic alt_en;
      logic alt_val;

      if (i < ASG_W) begin : g_addr
         assign alt_en  = asgn_q[i];
         assign alt_val = xa_addr[i];
      end else if (i == STROBE_PIN) begin : g_strobe
         assign alt_en  = strobe_on;
         assign alt_val = rw_strobe;
      end else begin : g_plain
         assign alt_en  = 1'b0;
         assign alt_val = 1'b0;
      end

      assign pin_oe[i]  = alt_en | dir_q[i];
      assign pin_out[i] = alt_en ? alt_val : data_q[i];

      always_comb begin
         if (alt_en)        port_rb[i] = alt_val;
         else if (dir_q[i]) port_rb[i] = data_q[i];
         else               port_rb[i] = sync_in[i];
      end
   end

endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
   import gpio_altport_pkg::*;
#(
   parameter int            W           = 8,
   parameter int            AW          = 8,
   parameter int            ASG_W       = 6,
   parameter int            STROBE_PIN  = 7,
   parameter int            SYNC_STAGES = 2,
   parameter logic [AW-1:0] DATA_A      = 8'h7E,
   parameter logic [AW-1:0] DIR_A       = 8'h7F,
   parameter logic [AW-1:0] ASG_A       = 8'h2D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic [W-1:0]     bus_wdata,
   output logic [W-1:0]     bus_rdata,
   input  logic [ASG_W-1:0] xa_addr,
   input  logic             rw_strobe,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pin_out,
   output logic [W-1:0]     pin_oe
);

   logic [W-1:0]     data_q;
   logic [W-1:0]     dir_q;
   logic [ASG_W-1:0] asgn_q;
   logic [W-1:0]     sync_in;
   logic [W-1:0]     port_rb;

   gpio_altport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_in)
   );

   gpio_altport_regs #(
      .W(W), .AW(AW), .ASG_W(ASG_W),
      .DATA_A(DATA_A), .DIR_A(DIR_A), .ASG_A(ASG_A)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .port_rb   (port_rb),
      .bus_rdata (bus_rdata),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .asgn_q    (asgn_q)
   );

   gpio_altport_pinmux #(.W(W), .ASG_W(ASG_W), .STROBE_PIN(STROBE_PIN)) u_mux (
      .mode      (mode),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .asgn_q    (asgn_q),
      .xa_addr   (xa_addr),
      .rw_strobe (rw_strobe),
      .sync_in   (sync_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .port_rb   (port_rb)
   );

endmodule

// File: rtl/gpio_altport_chk.sv
module gpio_altport_chk #(
   parameter int            W          = 8,
   parameter int            AW         = 8,
   parameter int            ASG_W      = 6,
   parameter int            STROBE_PIN = 7,
   parameter logic [AW-1:0] DIR_A      = 8'h7F,
   parameter logic [AW-1:0] ASG_A      = 8'h2D
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [AW-1:0]    bus_addr,
   input logic             bus_wr,
   input logic [W-1:0]     bus_wdata,
   input logic [W-1:0]     bus_rdata,
   input logic [ASG_W-1:0] xa_addr,
   input logic             rw_strobe,
   input logic [W-1:0]     pin_out,
   input logic [W-1:0]     pin_oe,
   input logic [W-1:0]     dir_q,
   input logic [ASG_W-1:0] asgn_q
);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (pin_oe[STROBE_PIN-1:0] == '0));

   assert_plain_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[ASG_W] == dir_q[ASG_W]);

   assert_addr_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((asgn_q & ~pin_oe[ASG_W-1:0]) == '0) &&
      (((pin_out[ASG_W-1:0] ^ xa_addr) & asgn_q) == '0));

   assert_asg_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ASG_A) |-> (bus_rdata[W-1:ASG_W] == '0));

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((~asgn_q & (pin_oe[ASG_W-1:0] ^ dir_q[ASG_W-1:0])) == '0));

   assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode[0] |-> (pin_oe[STROBE_PIN] && (pin_out[STROBE_PIN] == rw_strobe)));

   assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_A) |=> (dir_q == $past(bus_wdata)));

endmodule

bind gpio_altport gpio_altport_chk #(
   .W(W), .AW(AW), .ASG_W(ASG_W), .STROBE_PIN(STROBE_PIN),
   .DIR_A(DIR_A), .ASG_A(ASG_A)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .xa_addr(xa_addr), .rw_strobe(rw_strobe), .pin_out(pin_out),
   .pin_oe(pin_oe), .dir_q(dir_q), .asgn_q(asgn_q)
);

// File: tb/gpio_altport_tb.sv
`timescale 1ns/1ps
module gpio_altport_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [5:0] xa_addr = 6'h00;
   logic       rw_strobe = 1'b0;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_altport u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .xa_addr(xa_addr), .rw_strobe(rw_strobe), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 oe", pin_oe, 8'h00);
      rd(8'h7F, v); chk("R1 dir", v, 8'h00);
      rd(8'h2D, v); chk("R1 asg", v, 8'h00);
      rd(8'h7E, v); chk("R1 data", v, 8'h00);

      // R9 write timing: old value before edge, new after
      @(negedge clk);
      bus_addr = 8'h7F; bus_wdata = 8'hF0; bus_wr = 1'b1;
      #1; chk("R9 before edge", bus_rdata, 8'h00);
      @(negedge clk); bus_wr = 1'b0;
      #1; chk("R9 after edge", bus_rdata, 8'hF0);

      // R2 plain output / input
      wr(8'h7E, 8'h3C);
      chk("R2 oe", pin_oe, 8'hF0);
      chk("R2 out", pin_out, 8'h3C);

      // R8 input latency: two edges
      @(negedge clk); pin_in = 8'h0F;
      @(negedge clk); rd(8'h7E, v); chk("R8 one edge", v, 8'h30);
      @(negedge clk); rd(8'h7E, v); chk("R8 two edges", v, 8'h3F);

      // R4 unimplemented bits
      wr(8'h2D, 8'hFF);
      rd(8'h2D, v); chk("R4 asg read", v, 8'h3F);
      // R3 direction register untouched by override
      rd(8'h7F, v); chk("R3 dir kept", v, 8'hF0);
      xa_addr = 6'h2A; #1;
      chk("R3 out", pin_out, 8'h2A | (8'h3C & 8'hC0));
      chk("R3 oe", pin_oe, 8'hFF);
      rd(8'h7E, v); chk("R8 alt readback", v, 8'h2A);

      // R5 release
      wr(8'h2D, 8'h00);
      chk("R5 oe", pin_oe, 8'hF0);
      chk("R5 out", pin_out, 8'h3C);

      // R7 decode miss
      wr(8'h7D, 8'hAA);
      rd(8'h7D, v); chk("R7 miss read", v, 8'h00);
      rd(8'h7F, v); chk("R7 dir intact", v, 8'hF0);
      rd(8'h2D, v); chk("R7 asg intact", v, 8'h00);
      rd(8'h7E, v); chk("R7 data intact", v, 8'h3F);

      // R6 mode sweep on pin 7 with direction 0
      wr(8'h7F, 8'h00);
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 2; s++) begin
            mode = m[1:0]; rw_strobe = s[0]; #1;
            chk("R6 oe7", {7'd0, pin_oe[7]}, {7'd0, m[0]});
            chk("R6 out7", {7'd0, pin_out[7]}, {7'd0, m[0] ? s[0] : 1'b0});
         end
      end

      // Sweep all assignment patterns (R2 R3 R5 R6 R8)
      pin_in = 8'h96;
      for (int a = 0; a < 64; a++) begin
         logic [7:0] dirv, lat, amask, aval, eout, eoe;
         logic [5:0] xv;
         dirv = 8'((a * 37) & 8'hFF);
         lat  = 8'((a * 11 + 5) & 8'hFF);
         xv   = 6'((a * 5 + 3) & 6'h3F);
         wr(8'h7F, dirv);
         wr(8'h7E, lat);
         wr(8'h2D, 8'(a));
         mode = 2'(a); rw_strobe = a[2]; xa_addr = xv;
         #1;
         amask = {mode[0], 1'b0, 6'(a)};
         aval  = {rw_strobe, 1'b0, xv};
         eout  = (aval & amask) | (lat & ~amask);
         eoe   = dirv | amask;
         chk("R3 sweep out", pin_out, eout);
         chk("R2 sweep oe", pin_oe, eoe);
         rd(8'h7F, v); chk("R5 sweep dir", v, dirv);
         rd(8'h7E, v); chk("R8 sweep rb", v, (eout & eoe) | (8'h96 & ~eoe));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule